// File: doc/BRIEF.md
# Four-Channel DMA Controller Register File

This block is the register side of a four-channel DMA controller in the classic style, reached over an 8-bit I/O bus. A 4-bit register index is taken from the bus port address after a fixed width shift. The shift is 0 for a byte-wide controller and 1 for a word-wide one. The lower eight indices reach the per-channel address and count registers, which are 16 bits wide. A single byte-pointer toggle, shared by all four channels, carries each of them across the 8-bit bus in two halves. The upper eight indices form the control space: command, request, single mask, mode, pointer clear, master clear, mask clear-all and mask write-all.

A transfer scheduler sits beside the block. It sees the mask, request, mode and command state as plain outputs. It writes the progress count of a channel back through a one-cycle strobe and flags terminal counts. Peripherals raise and drop their requests through per-channel hold and release pins. The bus interface is a plain register strobe interface with no handshake: every read or write completes in the cycle it is presented, and read data is combinational during the read cycle.

Top module: `dma_regif`

## Requirements
- R1: After hardware reset all four mask bits are set, requests and terminal counts are clear, the command is 0 and the byte pointer selects the low byte.
- R2: The register index is bits 3:0 of (port >> WSHIFT). Index bit 3 = 0 selects a channel register: channel = index bits 2:1, and index bit 0 picks address (0) or count (1).
- R3: Every channel-register read or write uses the byte pointer (0 = low byte, 1 = high byte) and then inverts it. A write to index 0xC sets the pointer back to 0.
- R4: A high-byte write to a channel register reloads that channel's current address from (base address << WSHIFT) and zeroes its progress.
- R5: An address read yields current address + progress, or current address − progress when mode bit 5 of that channel is 1. The byte returned is (value >> (WSHIFT + 8 × pointer)) bits 7:0.
- R6: A count read yields (base count << WSHIFT) − progress, with its byte picked the same way as in R5.
- R7: A write to index 8 loads the command only when the data is 0 or has no bit set other than bit 2. Any other value leaves the command unchanged.
- R8: A write to index 9 takes the channel from data bits 1:0 and sets or clears that channel's request to the value of data bit 2. It always clears that channel's terminal-count flag.
- R9: A write to index 0xA sets or clears the mask of channel data[1:0] according to data bit 2. Index 0xE clears all masks. Index 0xF loads the masks from data bits 3:0. A read of 0xF returns {4'b0, mask}.
- R10: A write to index 0xB stores the whole data byte as the mode of channel data[1:0]. The mode is presented at mode_o bits 8×ch+7:8×ch.
- R11: A write to index 0xD clears the pointer, requests, terminal counts and command, and sets all masks. It does not change the modes or the channel registers.
- R12: A read of index 8 returns the status byte {request[3:0], terminal_count[3:0]} and then clears the terminal-count flags. A terminal count raised on tc_set in the same cycle survives. Reads of indices 9 to 0xE return 0.
- R13: hold_req bits set requests and release_req bits clear them. These inputs are applied after any bus write in the same cycle, and a release wins over a hold on the same channel.
- R14: A prog_we strobe writes prog_val into the progress count of channel prog_ch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_port | input | PORT_W | I/O port address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid during the read cycle |
| hold_req | input | 4 | Per-channel request set |
| release_req | input | 4 | Per-channel request clear |
| tc_set | input | 4 | Per-channel terminal-count flag set |
| prog_we | input | 1 | Progress write-back strobe |
| prog_ch | input | 2 | Channel for progress write-back |
| prog_val | input | 16+WSHIFT | New progress value |
| mask_o | output | 4 | Channel mask bits |
| req_o | output | 4 | Channel request-pending bits |
| mode_o | output | 32 | Four mode bytes, channel 0 lowest |
| cmd_o | output | 8 | Command register |

## Verification
The assertions assume that read and write never share a cycle and that a progress write-back never lands in the same cycle as a high-byte write to the same channel. Under those conditions the reload-versus-update order never comes up. The mode and command properties also take it that only one bus write is presented per cycle. The stimulus drives a single operation per clock. The only exception is the deliberate pairing of a hold input with a request write, which checks the precedence rule. Hold and release on the same channel are exercised only one at a time.

// File: rtl/dma_regif_pkg.sv
package dma_regif_pkg;
  localparam int NCH  = 4;
  localparam int CH_W = 2;
  localparam int IDX_W = 4;

  typedef enum logic [IDX_W-1:0] {
    IX_CMD     = 4'h8,
    IX_REQ     = 4'h9,
    IX_MASK1   = 4'hA,
    IX_MODE    = 4'hB,
    IX_PTRCLR  = 4'hC,
    IX_MCLR    = 4'hD,
    IX_MASKCLR = 4'hE,
    IX_MASKALL = 4'hF
  } ctl_idx_e;

  localparam logic [7:0] CMD_ALLOWED = 8'h04;
  localparam int DIR_BIT = 5;
endpackage

// File: rtl/dma_idx_decode.sv
module dma_idx_decode
  import dma_regif_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int WSHIFT = 0
) (
  input  logic [PORT_W-1:0] port,
  output logic [IDX_W-1:0]  idx,
  output logic              is_chan,
  output logic [CH_W-1:0]   chan,
  output logic              sel_cnt
);
  // R2: shift out the width bits, keep four index bits
  assign idx     = IDX_W'(port >> WSHIFT);
  assign is_chan = ~idx[3];
  assign chan    = idx[2:1];
  assign sel_cnt = idx[0];
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regif_pkg::*;
#(
  parameter int WSHIFT = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 sel_cnt,
  input  logic                 ptr,
  input  logic [7:0]           wdata,
  input  logic                 mode_we,
  input  logic                 prog_we,
  input  logic [15+WSHIFT:0]   prog_val,
  output logic [7:0]           addr_byte,
  output logic [7:0]           cnt_byte,
  output logic [7:0]           mode
);
  localparam int AW = 16 + WSHIFT;

  logic [15:0]   base_addr, base_cnt;
  logic [AW-1:0] cur_addr, prog;
  logic [15:0]   old_word, new_word, next_addr;
  logic [AW-1:0] addr_val, cnt_val;
  int unsigned   sh_amt;

  // R3: byte merge picked by the shared pointer
  always_comb begin
    old_word = sel_cnt ? base_cnt : base_addr;
    new_word = ptr ? {wdata, old_word[7:0]} : {old_word[15:8], wdata};
    next_addr = (wr_en && !sel_cnt) ? new_word : base_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr <= '0;
      base_cnt  <= '0;
      cur_addr  <= '0;
      prog      <= '0;
      mode      <= '0;
    end else begin
      if (wr_en && !sel_cnt) base_addr <= new_word;
      if (wr_en && sel_cnt)  base_cnt  <= new_word;
      if (mode_we)           mode      <= wdata;           // R10
      if (wr_en && ptr) begin                               // R4
        cur_addr <= AW'(next_addr) << WSHIFT;
        prog     <= '0;
      end else if (prog_we) begin                           // R14
        prog <= prog_val;
      end
    end
  end

  // R5 / R6: read values and byte selection
  always_comb begin
    addr_val = mode[DIR_BIT] ? (cur_addr - prog) : (cur_addr + prog);
    cnt_val  = (AW'(base_cnt) << WSHIFT) - prog;
    sh_amt   = ptr ? (WSHIFT + 8) : WSHIFT;
    addr_byte = 8'(addr_val >> sh_amt);
    cnt_byte  = 8'(cnt_val >> sh_amt);
  end
endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
  import dma_regif_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_we,
  input  logic            req_we,
  input  logic            mask1_we,
  input  logic            ptr_clr,
  input  logic            mclr,
  input  logic            mask_clr,
  input  logic            mask_all_we,
  input  logic            stat_rd,
  input  logic            chan_acc,
  input  logic [7:0]      wdata,
  input  logic [NCH-1:0]  hold_req,
  input  logic [NCH-1:0]  release_req,
  input  logic [NCH-1:0]  tc_set,
  output logic [7:0]      cmd,
  output logic [NCH-1:0]  mask,
  output logic [NCH-1:0]  req,
  output logic [NCH-1:0]  tc,
  output logic            ptr
);
  logic [NCH-1:0] req_n, tc_n, mask_n;
  logic [7:0]     cmd_n;
  logic           ptr_n;
  logic [CH_W-1:0] wch;
  logic           cmd_ok;

  assign wch    = wdata[CH_W-1:0];
  assign cmd_ok = (wdata == 8'h00) || ((wdata & ~CMD_ALLOWED) == 8'h00);  // R7

  always_comb begin
    req_n  = req;
    tc_n   = tc;
    mask_n = mask;
    cmd_n  = cmd;
    ptr_n  = ptr;
    if (chan_acc) ptr_n = ~ptr;                             // R3
    if (ptr_clr)  ptr_n = 1'b0;
    if (mclr) begin                                         // R11
      ptr_n  = 1'b0;
      req_n  = '0;
      tc_n   = '0;
      cmd_n  = '0;
      mask_n = '1;
    end
    if (cmd_we && cmd_ok) cmd_n = wdata;
    if (req_we) begin                                       // R8
      req_n[wch] = wdata[2];
      tc_n[wch]  = 1'b0;
    end
    if (mask1_we)    mask_n[wch] = wdata[2];                // R9
    if (mask_clr)    mask_n = '0;
    if (mask_all_we) mask_n = wdata[NCH-1:0];
    if (stat_rd)     tc_n = '0;                             // R12
    tc_n  = tc_n | tc_set;
    req_n = (req_n | hold_req) & ~release_req;              // R13
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin                                       // R1
      req  <= '0;
      tc   <= '0;
      mask <= '1;
      cmd  <= '0;
      ptr  <= 1'b0;
    end else begin
      req  <= req_n;
      tc   <= tc_n;
      mask <= mask_n;
      cmd  <= cmd_n;
      ptr  <= ptr_n;
    end
  end
endmodule

// File: rtl/dma_regif.sv
module dma_regif
  import dma_regif_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int WSHIFT = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PORT_W-1:0]    bus_port,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [7:0]           bus_wdata,
  output logic [7:0]           bus_rdata,
  input  logic [3:0]           hold_req,
  input  logic [3:0]           release_req,
  input  logic [3:0]           tc_set,
  input  logic                 prog_we,
  input  logic [1:0]           prog_ch,
  input  logic [15+WSHIFT:0]   prog_val,
  output logic [3:0]           mask_o,
  output logic [3:0]           req_o,
  output logic [31:0]          mode_o,
  output logic [7:0]           cmd_o
);
  logic [IDX_W-1:0] idx;
  logic             is_chan, sel_cnt, ptr;
  logic [CH_W-1:0]  chan;
  logic             cw, wr_chan, rd_chan;
  logic [NCH-1:0]   req, tc, mask;
  logic [7:0]       a_byte [NCH];
  logic [7:0]       c_byte [NCH];
  logic [7:0]       mode_q [NCH];

  dma_idx_decode #(.PORT_W(PORT_W), .WSHIFT(WSHIFT)) u_dec (
    .port(bus_port), .idx(idx), .is_chan(is_chan), .chan(chan), .sel_cnt(sel_cnt)
  );

  assign cw      = bus_wr & ~is_chan;
  assign wr_chan = bus_wr & is_chan;
  assign rd_chan = bus_rd & is_chan;

  dma_ctrl_regs u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_we      (cw && idx == IX_CMD),
    .req_we      (cw && idx == IX_REQ),
    .mask1_we    (cw && idx == IX_MASK1),
    .ptr_clr     (cw && idx == IX_PTRCLR),
    .mclr        (cw && idx == IX_MCLR),
    .mask_clr    (cw && idx == IX_MASKCLR),
    .mask_all_we (cw && idx == IX_MASKALL),
    .stat_rd     (bus_rd && idx == IX_CMD),
    .chan_acc    (wr_chan | rd_chan),
    .wdata       (bus_wdata),
    .hold_req    (hold_req),
    .release_req (release_req),
    .tc_set      (tc_set),
    .cmd         (cmd_o),
    .mask        (mask),
    .req         (req),
    .tc          (tc),
    .ptr         (ptr)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dma_chan_regs #(.WSHIFT(WSHIFT)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_chan && chan == CH_W'(g)),
      .sel_cnt   (sel_cnt),
      .ptr       (ptr),
      .wdata     (bus_wdata),
      .mode_we   (cw && idx == IX_MODE && bus_wdata[CH_W-1:0] == CH_W'(g)),
      .prog_we   (prog_we && prog_ch == CH_W'(g)),
      .prog_val  (prog_val),
      .addr_byte (a_byte[g]),
      .cnt_byte  (c_byte[g]),
      .mode      (mode_q[g])
    );
    assign mode_o[8*g +: 8] = mode_q[g];
  end

  assign mask_o = mask;
  assign req_o  = req;

  // R12 / R9: read data mux
  always_comb begin
    bus_rdata = 8'h00;
    if (bus_rd) begin
      if (is_chan)              bus_rdata = sel_cnt ? c_byte[chan] : a_byte[chan];
      else if (idx == IX_CMD)   bus_rdata = {req, tc};
      else if (idx == IX_MASKALL) bus_rdata = {4'b0000, mask};
    end
  end
endmodule

// File: rtl/dma_regif_chk.sv
module dma_regif_chk #(
  parameter int PORT_W = 8,
  parameter int WSHIFT = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PORT_W-1:0] bus_port,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [7:0]        bus_wdata,
  input logic [3:0]        hold_req,
  input logic [3:0]        release_req,
  input logic [3:0]        mask_o,
  input logic [3:0]        req_o,
  input logic [31:0]       mode_o,
  input logic [7:0]        cmd_o
);
  logic [3:0] cidx;
  logic [3:0] hset;
  assign cidx = 4'(bus_port >> WSHIFT);
  assign hset = hold_req & ~release_req;

  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd));                                                         // R2
  AST_CMD_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && cidx == 4'h8 && bus_wdata != 8'h00 && (bus_wdata & 8'hFB) != 8'h00) |=> $stable(cmd_o)); // R7
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && cidx == 4'hE) |=> mask_o == 4'h0);                                // R9
  AST_MODE_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && cidx == 4'hB) |=> 8'(mode_o >> (8 * $past(bus_wdata[1:0]))) == $past(bus_wdata)); // R10
  AST_MCLR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && cidx == 4'hD) |=> (mask_o == 4'hF && cmd_o == 8'h00 && req_o == $past(hset))); // R11
  AST_HOLD_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (|hset) |=> ((req_o & $past(hset)) == $past(hset)));                         // R13
  AST_REL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (|release_req) |=> ((req_o & $past(release_req)) == 4'h0));                  // R13
endmodule

bind dma_regif dma_regif_chk #(.PORT_W(PORT_W), .WSHIFT(WSHIFT)) u_chk (.*);

// File: tb/sim_dma_regif.sv
module sim_dma_regif;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_port = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [3:0]  hold_req = '0, release_req = '0, tc_set = '0;
  logic        prog_we = 1'b0;
  logic [1:0]  prog_ch = '0;
  logic [15:0] prog_val = '0;
  logic [3:0]  mask_o, req_o;
  logic [31:0] mode_o;
  logic [7:0]  cmd_o;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_regif u0 (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one-cycle operation, driven just after the rising edge
  task automatic drive(input bit wr, input bit rd, input logic [7:0] port, input logic [7:0] d,
                       input logic [3:0] hold, input logic [3:0] rel);
    @(posedge clk); #1;
    bus_wr = wr; bus_rd = rd; bus_port = port; bus_wdata = d;
    hold_req = hold; release_req = rel;
    @(posedge clk); #1;
    bus_wr = 0; bus_rd = 0; hold_req = 0; release_req = 0;
  endtask

  task automatic wr(input logic [7:0] port, input logic [7:0] d);
    drive(1, 0, port, d, 4'h0, 4'h0);
  endtask

  // scoreboard driver: push expectation then issue the read
  task automatic rd(input logic [7:0] port, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    drive(0, 1, port, 8'h00, 4'h0, 4'h0);
  endtask

  task automatic side(input logic [3:0] tc, input bit pwe, input logic [1:0] pch, input logic [15:0] pv);
    @(posedge clk); #1;
    tc_set = tc; prog_we = pwe; prog_ch = pch; prog_val = pv;
    @(posedge clk); #1;
    tc_set = 0; prog_we = 0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && bus_rd) begin
      if (exp_q.size() == 0) chk(0, "read with empty queue", bus_rdata, 0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(bus_rdata == e, t, bus_rdata, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk(mask_o == 4'hF, "R1 mask", mask_o, 4'hF);
    chk(req_o == 4'h0, "R1 req", req_o, 0);
    chk(cmd_o == 8'h00, "R1 cmd", cmd_o, 0);
    rd(8'h08, 8'h00, "R1 status");
    rd(8'h0F, 8'h0F, "R9 mask read after reset");
    // R3 R5 channel 0 address
    wr(8'h00, 8'h34); wr(8'h00, 8'h12);
    rd(8'h00, 8'h34, "R3 addr low"); rd(8'h00, 8'h12, "R3 addr high");
    // R6 count
    wr(8'h01, 8'h10); wr(8'h01, 8'h00);
    rd(8'h01, 8'h10, "R6 count low"); rd(8'h01, 8'h00, "R6 count high");
    // R14 progress
    side(4'h0, 1, 2'd0, 16'd5);
    rd(8'h00, 8'h39, "R14 R5 addr+prog low"); rd(8'h00, 8'h12, "R5 addr+prog high");
    rd(8'h01, 8'h0B, "R6 count-prog low"); rd(8'h01, 8'h00, "R6 count-prog high");
    // R10 mode, R5 decrement
    wr(8'h0B, 8'h20);
    chk(mode_o[7:0] == 8'h20, "R10 mode ch0", mode_o[7:0], 8'h20);
    rd(8'h00, 8'h2F, "R5 decrement low"); rd(8'h00, 8'h12, "R5 decrement high");
    // R3 pointer clear
    rd(8'h00, 8'h2F, "R3 low before clear");
    wr(8'h0C, 8'h00);
    rd(8'h00, 8'h2F, "R3 low after clear");
    wr(8'h0C, 8'h00);
    // R4 reload on high write
    wr(8'h00, 8'h00); wr(8'h00, 8'h40);
    rd(8'h00, 8'h00, "R4 reload low"); rd(8'h00, 8'h40, "R4 reload high");
    rd(8'h01, 8'h10, "R4 prog cleared"); rd(8'h01, 8'h00, "R4 prog cleared high");
    // R2 channel 2 decode
    wr(8'h04, 8'hAB); wr(8'h04, 8'hCD);
    rd(8'h04, 8'hAB, "R2 ch2 low"); rd(8'h04, 8'hCD, "R2 ch2 high");
    rd(8'h00, 8'h00, "R2 ch0 untouched"); rd(8'h00, 8'h40, "R2 ch0 untouched high");
    // R7 command
    wr(8'h08, 8'h04);
    chk(cmd_o == 8'h04, "R7 accept", cmd_o, 8'h04);
    wr(8'h08, 8'h11);
    chk(cmd_o == 8'h04, "R7 reject", cmd_o, 8'h04);
    wr(8'h08, 8'h00);
    chk(cmd_o == 8'h00, "R7 zero", cmd_o, 0);
    // R9 masks
    wr(8'h0E, 8'h00);
    chk(mask_o == 4'h0, "R9 clear all", mask_o, 0);
    wr(8'h0A, 8'h06);
    chk(mask_o == 4'h4, "R9 single set", mask_o, 4);
    wr(8'h0A, 8'h02);
    chk(mask_o == 4'h0, "R9 single clear", mask_o, 0);
    wr(8'h0F, 8'hFA);
    chk(mask_o == 4'hA, "R9 write all", mask_o, 4'hA);
    rd(8'h0F, 8'h0A, "R9 mask read");
    // R8 R12 requests and terminal counts
    wr(8'h09, 8'h05);
    chk(req_o == 4'h2, "R8 set req", req_o, 2);
    side(4'h8, 0, 2'd0, 16'd0);
    rd(8'h08, 8'h28, "R12 status"); rd(8'h08, 8'h20, "R12 tc cleared");
    side(4'h2, 0, 2'd0, 16'd0);
    wr(8'h09, 8'h01);
    chk(req_o == 4'h0, "R8 clear req", req_o, 0);
    rd(8'h08, 8'h00, "R8 tc cleared by request write");
    for (int i = 9; i <= 14; i++) rd(8'(i), 8'h00, "R12 other control read");
    // R13 hold and release
    drive(0, 0, 8'h00, 8'h00, 4'h4, 4'h0);
    chk(req_o == 4'h4, "R13 hold", req_o, 4);
    drive(0, 0, 8'h00, 8'h00, 4'h0, 4'h4);
    chk(req_o == 4'h0, "R13 release", req_o, 0);
    drive(1, 0, 8'h09, 8'h00, 4'h1, 4'h0);
    chk(req_o == 4'h1, "R13 precedence over write", req_o, 1);
    drive(0, 0, 8'h00, 8'h00, 4'h0, 4'h1);
    // R11 master clear
    wr(8'h08, 8'h04); wr(8'h09, 8'h06);
    side(4'h1, 0, 2'd0, 16'd0);
    rd(8'h00, 8'h00, "R11 pointer to high");
    wr(8'h0D, 8'h00);
    chk(mask_o == 4'hF, "R11 mask", mask_o, 4'hF);
    chk(req_o == 4'h0, "R11 req", req_o, 0);
    chk(cmd_o == 8'h00, "R11 cmd", cmd_o, 0);
    chk(mode_o[7:0] == 8'h20, "R11 mode kept", mode_o[7:0], 8'h20);
    rd(8'h08, 8'h00, "R11 status");
    rd(8'h00, 8'h00, "R11 pointer low"); rd(8'h00, 8'h40, "R11 addr kept");
    repeat (2) @(posedge clk);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule